// File: doc/BRIEF.md
# Touch ADC Dual-Axis SPI Sequencer

This block is an SPI master that collects one X/Y position pair from a resistive-touch ADC controller. A one-cycle `start` pulse pulls the chip select low once. The block then runs two 24-clock conversion frames back to back, with no release of chip select between them. The first frame asks for the X axis and the second asks for the Y axis. In each frame the block shifts out a fixed 8-bit control byte, MSB first. It then keeps MOSI low while the converter returns its answer.

The serial clock rests high, as in SPI mode 3. MOSI changes on the falling SCK edge and MISO is sampled on the rising edge. One bit-time after the control byte is treated as the converter's busy slot and is skipped. The next twelve bits are the conversion sample, and the last three bits are dropped. When the second frame ends, chip select rises, both samples are zero-extended to 16 bits and packed into one 32-bit word, and `done` pulses.

The SCK half-period is derived from two parameters, the system clock rate and the maximum SCK rate.

Top module: `touch_xy_reader`

## Requirements
- R1: A `start` pulse while idle raises `busy`, pulls `cs_n` low and runs two conversion frames. `busy` falls when the result is delivered.
- R2: `cs_n` goes low once per transaction and stays low through both frames. It rises only after the last rising SCK edge of the second frame, while SCK is high.
- R3: Each frame has exactly 24 SCK cycles, so a transaction has 48 rising and 48 falling SCK edges.
- R4: MOSI changes on falling SCK edges and is sent MSB first. Frame 0 carries control byte 0x90 (X axis) and frame 1 carries 0xD0 (Y axis). MOSI is low during the 16 readback bit-times of each frame (bit positions 8 to 23).
- R5: SCK is high whenever the block is idle. The first SCK edge after `cs_n` falls is a falling edge.
- R6: MISO is sampled on rising SCK edges. Within a frame (positions 0 to 23), position 8 is skipped. Positions 9 to 20 form the 12-bit sample, MSB first. Positions 21 to 23 are discarded.
- R7: `result[15:0]` holds the frame-0 sample zero-extended to 16 bits. `result[31:16]` holds the frame-1 sample zero-extended to 16 bits.
- R8: `done` is high for exactly one system clock per transaction, in the same cycle that `result` takes its new value and `busy` is low. `result` holds its value until the next transaction completes.
- R9: A `start` pulse that arrives while `busy` is high is ignored: it causes no restart and no extra `done`.
- R10: The SCK half-period, in system clocks, is max(2, (SYS_HZ / SCK_MAX_HZ) / 2 + 1). The first falling SCK edge comes one half-period after `cs_n` falls.
- R11: While reset is active and just after it: `cs_n` = 1, `sck` = 1, `mosi` = 0, `busy` = 0, `done` = 0 and `result` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one X/Y read; ignored while busy |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle strobe when the result updates |
| result | output | 32 | {Y sample, X sample}, each zero-extended to 16 bits |
| sck | output | 1 | SPI clock, rests high |
| mosi | output | 1 | Serial command data to the converter |
| miso | input | 1 | Serial conversion data from the converter |
| cs_n | output | 1 | Active-low chip select |

## Verification
A bit-position or frame counter that is off by one shows up at the ports as soon as the transaction ends. The edge count seen under `cs_n` is then not 48, a control byte is captured wrongly, or a sample in `result` is shifted one bit. A wrong capture window or axis order corrupts `result` in the same `done` cycle. A divider fault changes the spacing of SCK edges from the very first edge after `cs_n` falls. A sequencer that honours `start` while busy shows a second `done` strobe.

// File: rtl/touch_pkg.sv
package touch_pkg;
  localparam int CMD_BITS    = 8;
  localparam int SKIP_BITS   = 1;
  localparam int SAMPLE_BITS = 12;
  localparam int FRAME_BITS  = 24;
  localparam int NUM_FRAMES  = 2;
  localparam int FIELD_W     = 16;
  localparam int RESULT_W    = NUM_FRAMES * FIELD_W;

  localparam logic [CMD_BITS-1:0] CMD_AXIS_X = 8'b1001_0000;
  localparam logic [CMD_BITS-1:0] CMD_AXIS_Y = 8'b1101_0000;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_t;

  // system clocks per SCK half-period, never below two
  function automatic int half_period(input longint sys_hz, input longint sck_hz);
    longint v;
    v = (sys_hz / sck_hz) / 2 + 1;
    if (v < 2) v = 2;
    return int'(v);
  endfunction

  function automatic logic [CMD_BITS-1:0] frame_cmd(input int idx);
    return (idx == 0) ? CMD_AXIS_X : CMD_AXIS_Y;
  endfunction
endpackage

// File: rtl/touch_sck_div.sv
module touch_sck_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CNT_LAST);

  always_comb begin
    if (!run || cnt_q == CNT_LAST) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: ticks are at least two clocks apart
  a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/touch_tx_mux.sv
module touch_tx_mux
  import touch_pkg::*;
#(
  parameter int POS_W = 5,
  parameter int FRM_W = 1
) (
  input  logic [FRM_W-1:0] frm,
  input  logic [POS_W-1:0] pos,
  output logic             bit_o
);
  logic [CMD_BITS-1:0] cmd;
  logic [CMD_BITS-1:0] shifted;

  always_comb begin
    cmd     = frame_cmd(int'(frm));
    // shifting by the position runs the byte out MSB first, zero beyond it
    shifted = cmd << pos;
    bit_o   = shifted[CMD_BITS-1];
  end
endmodule

// File: rtl/touch_rx_capture.sv
module touch_rx_capture
  import touch_pkg::*;
#(
  parameter int POS_W = 5,
  parameter int FRM_W = 1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  clr,
  input  logic                                  rise_en,
  input  logic [FRM_W-1:0]                      frm,
  input  logic [POS_W-1:0]                      pos,
  input  logic                                  miso,
  output logic [NUM_FRAMES-1:0][SAMPLE_BITS-1:0] samples
);
  localparam int WIN_LO = CMD_BITS + SKIP_BITS;
  localparam int WIN_HI = WIN_LO + SAMPLE_BITS - 1;

  logic in_win;
  logic [NUM_FRAMES-1:0][SAMPLE_BITS-1:0] samp_q, samp_d;

  assign in_win  = (int'(pos) >= WIN_LO) && (int'(pos) <= WIN_HI);
  assign samples = samp_q;

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    always_comb begin
      samp_d[f] = samp_q[f];
      if (clr)
        samp_d[f] = '0;
      else if (rise_en && in_win && frm == FRM_W'(f))
        samp_d[f] = {samp_q[f][SAMPLE_BITS-2:0], miso};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) samp_q[f] <= '0;
      else        samp_q[f] <= samp_d[f];
    end
  end

  // R6: samples move only on a rising-edge capture or a clear
  a_r6_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_en && !clr) |=> $stable(samp_q));
endmodule

// File: rtl/touch_xy_reader.sv
module touch_xy_reader
  import touch_pkg::*;
#(
  parameter longint SYS_HZ     = 100_000_000,
  parameter longint SCK_MAX_HZ = 2_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                busy,
  output logic                done,
  output logic [RESULT_W-1:0] result,
  output logic                sck,
  output logic                mosi,
  input  logic                miso,
  output logic                cs_n
);
  localparam int HALF  = half_period(SYS_HZ, SCK_MAX_HZ);
  localparam int POS_W = $clog2(FRAME_BITS);
  localparam int FRM_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS - 1);
  localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(NUM_FRAMES - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  seq_state_t          state_q, state_d;
  logic                cs_q, cs_d, sck_q, sck_d, mosi_q, mosi_d;
  logic                phase_q, phase_d, fin_q, fin_d, done_q, done_d;
  logic [POS_W-1:0]    pos_q, pos_d;
  logic [FRM_W-1:0]    frm_q, frm_d;
  logic [RESULT_W-1:0] result_q, result_d, packed_w;
  logic                tick, accept, rise_en, tx_bit;
  logic [NUM_FRAMES-1:0][SAMPLE_BITS-1:0] samples;

  touch_sck_div #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_i), .run(state_q == ST_RUN), .tick(tick)
  );

  touch_tx_mux #(.POS_W(POS_W), .FRM_W(FRM_W)) u_tx (
    .frm(frm_q), .pos(pos_q), .bit_o(tx_bit)
  );

  touch_rx_capture #(.POS_W(POS_W), .FRM_W(FRM_W)) u_rx (
    .clk(clk), .rst_n(rst_i), .clr(accept), .rise_en(rise_en),
    .frm(frm_q), .pos(pos_q), .miso(miso), .samples(samples)
  );

  always_comb begin
    packed_w = '0;
    for (int f = 0; f < NUM_FRAMES; f++)
      packed_w[f*FIELD_W +: FIELD_W] = FIELD_W'(samples[f]);
  end

  always_comb begin
    state_d  = state_q;
    cs_d     = cs_q;
    sck_d    = sck_q;
    mosi_d   = mosi_q;
    phase_d  = phase_q;
    pos_d    = pos_q;
    frm_d    = frm_q;
    fin_d    = fin_q;
    done_d   = 1'b0;
    result_d = result_q;
    accept   = 1'b0;
    rise_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          accept  = 1'b1;
          state_d = ST_RUN;
          cs_d    = 1'b0;
          sck_d   = 1'b1;
          mosi_d  = 1'b0;
          phase_d = 1'b0;
          pos_d   = '0;
          frm_d   = '0;
          fin_d   = 1'b0;
        end
      end
      ST_RUN: begin
        if (tick) begin
          if (fin_q) begin
            cs_d     = 1'b1;
            mosi_d   = 1'b0;
            done_d   = 1'b1;
            result_d = packed_w;
            state_d  = ST_IDLE;
          end else if (!phase_q) begin
            sck_d   = 1'b0;
            mosi_d  = tx_bit;
            phase_d = 1'b1;
          end else begin
            sck_d   = 1'b1;
            rise_en = 1'b1;
            phase_d = 1'b0;
            if (pos_q == POS_LAST) begin
              pos_d = '0;
              if (frm_q == FRM_LAST) fin_d = 1'b1;
              else                   frm_d = frm_q + 1'b1;
            end else begin
              pos_d = pos_q + 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q  <= ST_IDLE;
      cs_q     <= 1'b1;
      sck_q    <= 1'b1;
      mosi_q   <= 1'b0;
      phase_q  <= 1'b0;
      pos_q    <= '0;
      frm_q    <= '0;
      fin_q    <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      state_q  <= state_d;
      cs_q     <= cs_d;
      sck_q    <= sck_d;
      mosi_q   <= mosi_d;
      phase_q  <= phase_d;
      pos_q    <= pos_d;
      frm_q    <= frm_d;
      fin_q    <= fin_d;
      done_q   <= done_d;
      result_q <= result_d;
    end
  end

  assign busy   = (state_q == ST_RUN);
  assign done   = done_q;
  assign result = result_q;
  assign sck    = sck_q;
  assign mosi   = mosi_q;
  assign cs_n   = cs_q;

  // R2: chip select held low for the whole transaction
  a_r2_cs_low_busy: assert property (@(posedge clk) disable iff (!rst_i)
    busy |-> !cs_n);
  // R5: clock rests high when idle
  a_r5_sck_idle: assert property (@(posedge clk) disable iff (!rst_i)
    !busy |-> sck);
  // R4: MOSI low through the readback bit-times
  a_r4_mosi_readback: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && !sck && pos_q >= POS_W'(CMD_BITS)) |-> !mosi);
  // R8: done is a single-cycle strobe and coincides with idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_i)
    done |-> !busy);
  // R9: a start while busy does not end or restart the run
  a_r9_ignore_start: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && start && !fin_q) |=> busy);
  // R3: bit position never leaves the frame
  a_r3_pos_range: assert property (@(posedge clk) disable iff (!rst_i)
    pos_q <= POS_LAST);
endmodule

// File: tb/tb_touch_xy_reader.sv
module tb_touch_xy_reader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;   // (8 MHz / 2 MHz) / 2 + 1
  localparam int NVEC       = 6;
  // {x sample, y sample}
  localparam logic [NVEC-1:0][23:0] VEC = {
    {12'h123, 12'hABC}, {12'h000, 12'hFFF}, {12'hFFF, 12'h000},
    {12'hAAA, 12'h555}, {12'h801, 12'h001}, {12'h7E5, 12'h3C9}
  };

  logic clk, rst_n, start, busy, done, sck, mosi, miso, cs_n;
  logic [31:0] result;

  touch_xy_reader #(.SYS_HZ(8_000_000), .SCK_MAX_HZ(2_000_000)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .result(result), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int ntest = 0, nfail = 0, cycles = 0, done_cnt = 0;
  int rise_cnt = 0, fall_cnt = 0, last_rises = 0, last_falls = 0, mosi_bad = 0;
  logic [7:0]  cmd_sr;
  logic [7:0]  cmd_seen [2];
  logic [11:0] sx, sy;
  time t_cs_fall, t_cs_rise, t_last_rise, t_f0, t_f1;
  logic sck_at_cs_rise;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done === 1'b1) done_cnt <= done_cnt + 1;
  end

  // converter model: takes MOSI on rising SCK, drives MISO on falling SCK
  always @(posedge sck or posedge cs_n) begin
    if (cs_n === 1'b1) begin
      if (rise_cnt != 0) last_rises = rise_cnt;
      rise_cnt = 0;
    end else if (cs_n === 1'b0) begin
      cmd_sr = {cmd_sr[6:0], mosi};
      if (rise_cnt % 24 == 7 && rise_cnt < 48) cmd_seen[rise_cnt/24] = cmd_sr;
      if (rise_cnt % 24 >= 8 && mosi !== 1'b0) mosi_bad++;
      rise_cnt++;
      t_last_rise = $time;
    end
  end

  always @(negedge sck or posedge cs_n) begin
    if (cs_n !== 1'b0) begin
      miso = 1'b0;
      if (fall_cnt != 0) last_falls = fall_cnt;
      fall_cnt = 0;
    end else begin
      automatic int p  = rise_cnt % 24;
      automatic int fr = rise_cnt / 24;
      automatic logic [11:0] v = 12'h000;
      if (fr < 2) v = (cmd_seen[fr] == 8'h90) ? sx : (cmd_seen[fr] == 8'hD0) ? sy : 12'h000;
      miso = (p >= 9 && p <= 20) ? v[20-p] : 1'b0;
      if (fall_cnt == 0) t_f0 = $time;
      if (fall_cnt == 1) t_f1 = $time;
      fall_cnt++;
    end
  end

  always @(negedge cs_n) t_cs_fall = $time;
  always @(posedge cs_n) begin t_cs_rise = $time; sck_at_cs_rise = sck; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000; i++) begin
      if (done === 1'b1) return;
      @(negedge clk);
    end
    chk("R1 done timeout", 32'd0, 32'd1);
  endtask

  task automatic run_vec(input logic [11:0] x, input logic [11:0] y);
    int d0;
    sx = x; sy = y; mosi_bad = 0;
    d0 = done_cnt;
    pulse_start();
    chk("R1 busy after start", {31'd0, busy}, 32'd1);
    chk("R2 cs_n low after start", {31'd0, cs_n}, 32'd0);
    wait_done();
    chk("R7 packed result", result, {4'h0, y, 4'h0, x});
    chk("R8 busy low with done", {31'd0, busy}, 32'd0);
    chk("R3 rising edges", last_rises, 32'd48);
    chk("R3 falling edges", last_falls, 32'd48);
    chk("R4 frame0 cmd", {24'd0, cmd_seen[0]}, 32'h90);
    chk("R4 frame1 cmd", {24'd0, cmd_seen[1]}, 32'hD0);
    chk("R4 mosi low in readback", mosi_bad, 32'd0);
    chk("R10 cs to first fall", 32'(t_f0 - t_cs_fall), 32'(HALF*CLK_PERIOD));
    chk("R10 fall spacing", 32'(t_f1 - t_f0), 32'(2*HALF*CLK_PERIOD));
    chk("R2 cs rises after last rise", {31'd0, t_cs_rise > t_last_rise}, 32'd1);
    chk("R2 sck high at cs rise", {31'd0, sck_at_cs_rise}, 32'd1);
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done}, 32'd0);
    chk("R8 one done per run", done_cnt - d0, 32'd1);
  endtask

  initial begin
    start = 1'b0; sx = '0; sy = '0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 reset cs_n", {31'd0, cs_n}, 32'd1);
    chk("R11 reset sck", {31'd0, sck}, 32'd1);
    chk("R11 reset busy/done/mosi", {29'd0, busy, done, mosi}, 32'd0);
    chk("R11 reset result", result, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 sck idle high", {31'd0, sck}, 32'd1);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i][23:12], VEC[i][11:0]);

    // R9: restart attempts in the middle of a run
    begin
      int d0;
      sx = 12'h5A5; sy = 12'h0F0;
      d0 = done_cnt;
      pulse_start();
      repeat (60) @(negedge clk);
      pulse_start();
      repeat (100) @(negedge clk);
      pulse_start();
      wait_done();
      chk("R9 result unaffected", result, {4'h0, 12'h0F0, 4'h0, 12'h5A5});
      chk("R9 edges unaffected", last_rises, 32'd48);
      repeat (400) @(negedge clk);
      chk("R9 single done", done_cnt - d0, 32'd1);
      chk("R8 result holds", result, {4'h0, 12'h0F0, 4'h0, 12'h5A5});
      chk("R5 idle sck high", {31'd0, sck}, 32'd1);
    end

    // R1: back-to-back start right after done
    @(negedge clk);
    run_vec(12'hFFF, 12'hFFF);
    finish_run();
  end

  initial begin
    wait (cycles > 100000);
    chk("watchdog", 32'd0, 32'd1);
    finish_run();
  end
endmodule